// File: doc/BRIEF.md
# Triple-Redundant Serial Configuration Register

This block holds a wide configuration word that must survive single-bit upsets over a very long operating life. Software or a controller shifts the settings in one bit per enabled clock through a chain of plain flip-flops. A commit strobe then copies every chain bit into three independent storage copies. The parallel settings output for each bit is the majority of its three copies, so a single corrupted copy never reaches the settings.

Every cycle, each bit compares its three copies. When they disagree, all three are rewritten with the voted value on the next clock edge, and an active-low upset flag pulses for one cycle. A capture strobe copies the voted settings back into the shift chain, so the stored word can be read out serially and checked. A test-only injection port flips one chosen copy of one chosen bit, so that correction and reporting can be exercised.

Top module: `tmr_cfg_reg`

## Requirements
- R1: While rst_ni is low, and on the first cycle after release, cfg_o is all zeros, sdo_o is 0 and upset_no is 1.
- R2: On each clock edge with shift_en_i high and capture_i low, the chain moves one place toward bit 0 and sdi_i enters at bit WIDTH-1. sdo_o shows chain bit 0, so after WIDTH shifts the first bit presented sits at position 0 (the first bit in is the least significant).
- R3: With shift_en_i, capture_i and load_i low, sdo_o holds its value, and shifting never changes cfg_o until a commit.
- R4: A clock edge with load_i high writes each chain bit into all three copies, so cfg_o equals the chain contents from the cycle after the strobe.
- R5: cfg_o bit i is the majority of the three copies of bit i, so a single flipped copy leaves cfg_o unchanged.
- R6: On the first edge at which a bit's copies disagree and load_i is low, all three copies of that bit are rewritten with the voted value. A later flip of a different copy of the same bit therefore still leaves cfg_o unchanged.
- R7: upset_no goes low for exactly one cycle, starting on the edge at which the correction occurs (one edge after the fault appears). It stays high in the cycle in which the fault first becomes visible.
- R8: A clock edge with capture_i high loads cfg_o into the chain, so that sdo_o then presents cfg_o bit 0, then bit 1 and so on as shifting proceeds. capture_i has priority over shift_en_i.
- R9: load_i has priority over correction. In a cycle with a mismatch and load_i high, the copies take the chain value, no correction happens, and upset_no stays high on the next two cycles.
- R10: inj_en_i flips the copy of bit inj_bit_i selected by inj_copy_i (0, 1 and 2 are the three copies). The code 3 flips nothing, and an inj_bit_i of WIDTH or more flips nothing. Neither raises upset_no. An injection into a bit that is being corrected in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Serial data in |
| shift_en_i | input | 1 | Shift the chain by one place |
| load_i | input | 1 | Commit chain into the three copies |
| capture_i | input | 1 | Copy voted settings back into the chain |
| inj_en_i | input | 1 | Test: enable fault injection |
| inj_bit_i | input | $clog2(WIDTH) | Test: bit index to corrupt |
| inj_copy_i | input | 2 | Test: copy to flip (0..2, 3 = none) |
| sdo_o | output | 1 | Serial data out, chain bit 0 |
| cfg_o | output | WIDTH | Voted configuration word |
| upset_no | output | 1 | Active-low one-cycle upset pulse |

## Verification
Some properties are checked on every cycle. A commit puts the chain contents on cfg_o, and cfg_o never moves without a commit. One correction edge with no injection leaves every bit's copies in agreement. A flag pulse always follows a real mismatch in a non-commit cycle, and a capture puts cfg_o bit 0 on sdo_o. The bench scenarios show the rest: that the first serial bit lands at position 0, that readback returns the whole word in order, and that correction really rewrote the faulty copy (a second fault on another copy does not flip the vote). They also show that a commit cancels a pending correction without a flag, and that out-of-range injection codes do nothing.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;
  typedef enum logic [1:0] {
    COPY_A    = 2'd0,
    COPY_B    = 2'd1,
    COPY_C    = 2'd2,
    COPY_NONE = 2'd3
  } copy_sel_e;

  function automatic logic maj3(input logic [2:0] c);
    return (c[0] & c[1]) | (c[1] & c[2]) | (c[0] & c[2]);
  endfunction
endpackage

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int WIDTH = 165
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdi_i,
  input  logic             shift_en_i,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] voted_i,
  output logic [WIDTH-1:0] chain_o,
  output logic             sdo_o
);
  logic [WIDTH-1:0] chain_q;

  // capture wins over shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         chain_q <= '0;
    else if (capture_i)  chain_q <= voted_i;
    else if (shift_en_i) chain_q <= {sdi_i, chain_q[WIDTH-1:1]};
  end

  assign chain_o = chain_q;
  assign sdo_o   = chain_q[0];
endmodule

// File: rtl/cfg_tmr_cell.sv
module cfg_tmr_cell
  import tmr_cfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      d_i,
  input  logic      inj_hit_i,
  input  copy_sel_e inj_copy_i,
  output logic      vote_o,
  output logic      mism_o
);
  logic [2:0] copy_q;

  assign vote_o = maj3(copy_q);
  assign mism_o = !((copy_q[0] == copy_q[1]) && (copy_q[1] == copy_q[2]));

  // priority: commit > scrub > injection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      copy_q <= '0;
    end else if (load_i) begin
      copy_q <= {3{d_i}};
    end else if (mism_o) begin
      copy_q <= {3{vote_o}};
    end else if (inj_hit_i) begin
      unique case (inj_copy_i)
        COPY_A:  copy_q[0] <= ~copy_q[0];
        COPY_B:  copy_q[1] <= ~copy_q[1];
        COPY_C:  copy_q[2] <= ~copy_q[2];
        default: copy_q <= copy_q;
      endcase
    end
  end
endmodule

// File: rtl/cfg_upset_flag.sv
module cfg_upset_flag #(
  parameter int WIDTH = 165
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] mism_i,
  output logic             upset_no
);
  logic upset_nq;

  // low for one cycle after an edge that scrubbed at least one bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upset_nq <= 1'b1;
    else         upset_nq <= !((|mism_i) && !load_i);
  end

  assign upset_no = upset_nq;
endmodule

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_cfg_pkg::*;
#(
  parameter  int WIDTH = 165,
  localparam int IDXW  = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdi_i,
  input  logic             shift_en_i,
  input  logic             load_i,
  input  logic             capture_i,
  input  logic             inj_en_i,
  input  logic [IDXW-1:0]  inj_bit_i,
  input  logic [1:0]       inj_copy_i,
  output logic             sdo_o,
  output logic [WIDTH-1:0] cfg_o,
  output logic             upset_no
);
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] voted_w;
  logic [WIDTH-1:0] mism_w;
  copy_sel_e        inj_sel;

  assign inj_sel = copy_sel_e'(inj_copy_i);

  cfg_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sdi_i      (sdi_i),
    .shift_en_i (shift_en_i),
    .capture_i  (capture_i),
    .voted_i    (voted_w),
    .chain_o    (chain_q),
    .sdo_o      (sdo_o)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic hit;
    assign hit = inj_en_i && (inj_bit_i == IDXW'(i));
    cfg_tmr_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load_i),
      .d_i        (chain_q[i]),
      .inj_hit_i  (hit),
      .inj_copy_i (inj_sel),
      .vote_o     (voted_w[i]),
      .mism_o     (mism_w[i])
    );
  end

  cfg_upset_flag #(.WIDTH(WIDTH)) u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .mism_i   (mism_w),
    .upset_no (upset_no)
  );

  assign cfg_o = voted_w;
endmodule

// File: rtl/tmr_cfg_chk.sv
module tmr_cfg_chk #(
  parameter int WIDTH = 165
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             capture_i,
  input logic             inj_en_i,
  input logic             sdo_o,
  input logic             upset_no,
  input logic [WIDTH-1:0] cfg_o,
  input logic [WIDTH-1:0] chain_i,
  input logic [WIDTH-1:0] mism_i
);
  assert_load_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cfg_o == $past(chain_i));

  assert_vote_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_o));

  assert_scrub_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|mism_i) && !load_i && !inj_en_i) |=> (mism_i == '0));

  assert_flag_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upset_no |-> $past((|mism_i) && !load_i));

  assert_capture_sdo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> sdo_o == $past(cfg_o[0]));

  assert_load_no_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> upset_no);
endmodule

bind tmr_cfg_reg tmr_cfg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .capture_i (capture_i),
  .inj_en_i  (inj_en_i),
  .sdo_o     (sdo_o),
  .upset_no  (upset_no),
  .cfg_o     (cfg_o),
  .chain_i   (chain_q),
  .mism_i    (mism_w)
);

// File: tb/sim_tmr_cfg_reg.sv
`timescale 1ns/1ps
module sim_tmr_cfg_reg;
  localparam int W    = 165;
  localparam int IDXW = $clog2(W);
  localparam int NV   = 5;

  // vector table: pattern seed, bit to corrupt, copy to corrupt
  localparam logic [31:0] VSEED [NV] = '{32'h0000_0000, 32'h1234_5678, 32'hDEAD_BEEF,
                                          32'h0BAD_F00D, 32'h8000_0001};
  localparam int          VBIT  [NV] = '{0, 164, 82, 1, 163};
  localparam int          VCOPY [NV] = '{0, 1, 2, 1, 0};

  logic clk = 1'b0;
  logic rst_ni, sdi, shift_en, load, capture, inj_en;
  logic [IDXW-1:0] inj_bit;
  logic [1:0] inj_copy;
  logic sdo, upset_n;
  logic [W-1:0] cfg;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  tmr_cfg_reg #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sdi_i(sdi), .shift_en_i(shift_en),
    .load_i(load), .capture_i(capture), .inj_en_i(inj_en),
    .inj_bit_i(inj_bit), .inj_copy_i(inj_copy),
    .sdo_o(sdo), .cfg_o(cfg), .upset_no(upset_n)
  );

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: act cycles %0d exp done", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gen(input logic [31:0] seed);
    logic [31:0] s;
    logic [W-1:0] p;
    s = seed;
    for (int i = 0; i < W; i++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      p[i] = s[0];
    end
    return p;
  endfunction

  task automatic shift_in(input logic [W-1:0] p);
    for (int i = 0; i < W; i++) begin
      sdi = p[i];
      shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
    sdi = 1'b0;
  endtask

  task automatic commit();
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic inject(input int b, input int c);
    inj_en = 1'b1;
    inj_bit = IDXW'(b);
    inj_copy = 2'(c);
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic readback(output logic [W-1:0] rb);
    capture = 1'b1;
    @(negedge clk);
    capture = 1'b0;
    for (int i = 0; i < W; i++) begin
      rb[i] = sdo;
      shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  initial begin
    logic [W-1:0] pat, prev, rb, pb;
    logic s0;
    rst_ni = 1'b0; sdi = 1'b0; shift_en = 1'b0; load = 1'b0; capture = 1'b0;
    inj_en = 1'b0; inj_bit = '0; inj_copy = 2'd0;
    prev = '0;
    repeat (3) @(negedge clk);
    chk(cfg == '0 && sdo == 1'b0 && upset_n == 1'b1, "R1 in reset", cfg, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cfg == '0 && sdo == 1'b0 && upset_n == 1'b1, "R1 after release", cfg, '0);

    for (int v = 0; v < NV; v++) begin
      pat = gen(VSEED[v]);
      shift_in(pat);
      chk(sdo == pat[0], "R2 sdo shows first bit in", W'(sdo), W'(pat[0]));
      chk(cfg == prev, "R3 shift leaves cfg", cfg, prev);
      repeat (3) @(negedge clk);
      chk(sdo == pat[0], "R3 idle chain holds", W'(sdo), W'(pat[0]));
      commit();
      chk(cfg == pat, "R4 R2 commit lsb first", cfg, pat);
      prev = pat;
      inject(VBIT[v], VCOPY[v]);
      chk(cfg == pat, "R5 single copy masked", cfg, pat);
      chk(upset_n == 1'b1, "R7 flag high on fault cycle", W'(upset_n), W'(1));
      @(negedge clk);
      chk(upset_n == 1'b0, "R7 flag low on scrub", W'(upset_n), W'(0));
      @(negedge clk);
      chk(upset_n == 1'b1, "R7 flag one cycle", W'(upset_n), W'(1));
      inject(VBIT[v], (VCOPY[v] + 1) % 3);
      repeat (3) @(negedge clk);
      chk(cfg == pat, "R6 scrub rewrote faulty copy", cfg, pat);
      readback(rb);
      chk(rb == pat, "R8 serial readback", rb, pat);
    end

    // R8 capture wins over shift
    sdi = 1'b1; capture = 1'b1; shift_en = 1'b1;
    @(negedge clk);
    capture = 1'b0;
    chk(sdo == prev[0], "R8 capture priority bit0", W'(sdo), W'(prev[0]));
    @(negedge clk);
    shift_en = 1'b0; sdi = 1'b0;
    chk(sdo == prev[1], "R8 capture priority bit1", W'(sdo), W'(prev[1]));

    // R9 commit beats scrub
    pb = gen(32'hCAFE_1234);
    shift_in(pb);
    inject(5, 0);
    commit();
    chk(upset_n == 1'b1 && cfg == pb, "R9 commit no flag", cfg, pb);
    @(negedge clk);
    chk(upset_n == 1'b1, "R9 no late scrub", W'(upset_n), W'(1));
    @(negedge clk);
    chk(upset_n == 1'b1, "R9 copies clean", W'(upset_n), W'(1));
    prev = pb;

    // R10 ignored injection codes
    inject(7, 3);
    @(negedge clk);
    chk(upset_n == 1'b1 && cfg == prev, "R10 copy code 3 ignored", cfg, prev);
    @(negedge clk);
    chk(upset_n == 1'b1, "R10 copy code 3 no flag", W'(upset_n), W'(1));
    inject(W, 0);
    @(negedge clk);
    chk(upset_n == 1'b1 && cfg == prev, "R10 bit index out of range", cfg, prev);
    @(negedge clk);
    chk(upset_n == 1'b1, "R10 out of range no flag", W'(upset_n), W'(1));

    // R1 asynchronous reset mid-operation
    s0 = 1'b0;
    #1 rst_ni = 1'b0;
    #0.5;
    chk(cfg == '0 && sdo == s0 && upset_n == 1'b1, "R1 async reset", cfg, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cfg == '0 && upset_n == 1'b1, "R1 after second release", cfg, '0);

    report();
    $finish;
  end
endmodule